// File: doc/BRIEF.md
# Dual Compare Match Flag Unit

This block sits beside an 8-bit timer counter and watches the running count against two compare values that software loads over a simple register bus. Each of the two channels has a match flag, an interrupt enable and an interrupt request line. The raw equality of each channel is exported combinationally for a waveform generator. The generator also receives two status lines that mark when the count is at its all-ones maximum and at zero.

A flag is not set the moment equality appears. It is set at the timer tick that ends the count value, one tick after the equal value was loaded. Software clears a flag by writing a one to its bit in the flag register. The interrupt controller clears it by pulsing that channel's acknowledge input. A bus write to a compare register masks that channel for its next tick. A write to the counter, announced on a strobe, masks both channels. A freshly loaded equal pair therefore does not raise a flag.

Top module: `cmp_flag_unit`

## Requirements
- R1: `match[i]` is high in the same cycle exactly when `count` equals compare register i. `at_top` is high when `count` is all ones. `at_bottom` is high when `count` is zero.
- R2: Flag i becomes set at a clock edge where `tick` is high, `count` equals compare register i, and the channel is not masked. Without `tick`, equality never sets a flag.
- R3: `irq[i]` is high exactly when flag i is set and enable bit i is set.
- R4: A high `ack[i]` at a clock edge clears flag i.
- R5: A bus write to address 2 clears flag i when data bit i is one. A zero in data bit i leaves flag i unchanged.
- R6: When a set event and a clear request (ack or write-one) for the same flag meet at one clock edge, the flag ends up set.
- R7: A bus write to compare register i (address 0 for channel 0, address 1 for channel 1) masks channel i. A high `cnt_wr` masks both channels. A masked channel sets no flag at its next tick, and that tick removes the mask.
- R8: After reset, flags, enables and compare registers are zero. Read data by address: 0 gives compare 0, 1 gives compare 1, 2 gives the flags in bits 1:0, 3 gives the enables in bits 1:0. The upper bits read as zero.
- R9: A bus write to address 3 loads the enables from data bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer tick enable, one cycle per count step |
| count | input | W | Running counter value |
| cnt_wr | input | 1 | Strobe: the bus writes the counter this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Register read data |
| ack | input | 2 | Interrupt acknowledge per channel |
| irq | output | 2 | Interrupt request per channel |
| match | output | 2 | Raw equality per channel |
| at_top | output | 1 | Count is at its maximum |
| at_bottom | output | 1 | Count is zero |

## Verification
The bound checker watches several rules on every cycle. It confirms that a tick with an unmasked equality always sets the flag, even against a clear request. It confirms that a flag never rises without such a tick, that an acknowledge without a set clears the flag, and that a zero write to the flag register leaves a set flag alone. It also confirms that a request is never raised with its enable off, and that a masked tick never sets a flag. Other behaviours only the bench's scenarios can show: that the mask comes from compare writes and counter writes, the register readback map, the reset values, and the match, top and bottom outputs. The bench shows these with a behavioural model compared on every clock.

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         cnt_wr,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   ack,
  output logic [1:0]   irq,
  output logic [1:0]   match,
  output logic         at_top,
  output logic         at_bottom
);
  localparam logic [1:0] A_CMP0 = 2'd0;
  localparam logic [1:0] A_CMP1 = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_IE   = 2'd3;

  logic [W-1:0] cmp_q [2];
  logic [1:0]   flag_q, ie_q, sup_q;
  logic [1:0]   set_ev, clr_ev, cmp_wr;

  assign at_top    = &count;
  assign at_bottom = ~|count;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign match[i]  = (count == cmp_q[i]);
    assign set_ev[i] = tick & match[i] & ~sup_q[i];
    assign clr_ev[i] = ack[i] | (wr_en & (wr_addr == A_FLAG) & wr_data[i]);
    assign cmp_wr[i] = wr_en & (wr_addr == (i == 0 ? A_CMP0 : A_CMP1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[i]  <= '0;
        flag_q[i] <= 1'b0;
        sup_q[i]  <= 1'b0;
      end else begin
        if (set_ev[i])      flag_q[i] <= 1'b1;
        else if (clr_ev[i]) flag_q[i] <= 1'b0;
        if (cmp_wr[i] | cnt_wr) sup_q[i] <= 1'b1;
        else if (tick)          sup_q[i] <= 1'b0;
        if (cmp_wr[i]) cmp_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ie_q <= '0;
    else if (wr_en && wr_addr == A_IE)     ie_q <= wr_data[1:0];
  end

  assign irq = flag_q & ie_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CMP0:  rd_data = cmp_q[0];
      A_CMP1:  rd_data = cmp_q[1];
      A_FLAG:  rd_data[1:0] = flag_q;
      default: rd_data[1:0] = ie_q;
    endcase
  end
endmodule

module cmp_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] match,
  input logic [1:0] ack,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [1:0] wr_bits,
  input logic [1:0] flag_q,
  input logic [1:0] ie_q,
  input logic [1:0] sup_q,
  input logic [1:0] irq
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    assert_set_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && match[i] && !sup_q[i]) |=> flag_q[i]);
    assert_no_rise_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && match[i]) |=> !$rose(flag_q[i]));
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !(tick && match[i] && !sup_q[i])) |=> !flag_q[i]);
    assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && wr_en && wr_addr == 2'd2 && !wr_bits[i] && !ack[i]) |=> flag_q[i]);
    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && match[i] && !sup_q[i] && ack[i]) |=> flag_q[i]);
    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (ie_q[i] && flag_q[i]));
    assert_masked_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_q[i] && tick && !flag_q[i]) |=> !flag_q[i]);
  end
endmodule

bind cmp_flag_unit cmp_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .match(match), .ack(ack),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_bits(wr_data[1:0]),
  .flag_q(flag_q), .ie_q(ie_q), .sup_q(sup_q), .irq(irq)
);

// File: tb/sim_cmp_flag_unit.sv
module sim_cmp_flag_unit;
  logic       clk = 0, rst_n = 0, tick = 0, cnt_wr = 0, wr_en = 0;
  logic [7:0] count = 0, wr_data = 0, rd_data;
  logic [1:0] wr_addr = 0, rd_addr = 2, ack = 0, irq, match;
  logic       at_top, at_bottom;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cmp_flag_unit u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cnt_wr(cnt_wr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack(ack), .irq(irq), .match(match), .at_top(at_top), .at_bottom(at_bottom));

  int m_cmp[2], m_flag[2], m_ie[2], m_sup[2];

  always @(posedge clk) begin
    int nf[2], ns[2];
    if (!rst_n) begin
      foreach (m_cmp[i]) begin m_cmp[i] = 0; m_flag[i] = 0; m_ie[i] = 0; m_sup[i] = 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit st, cl, cw;
        st = tick && (int'(count) == m_cmp[i]) && m_sup[i] == 0;
        cl = ack[i] || (wr_en && wr_addr == 2 && wr_data[i]);
        cw = wr_en && wr_addr == i;
        nf[i] = st ? 1 : (cl ? 0 : m_flag[i]);
        ns[i] = (cw || cnt_wr) ? 1 : (tick ? 0 : m_sup[i]);
      end
      for (int i = 0; i < 2; i++) begin
        if (wr_en && wr_addr == i) m_cmp[i] = int'(wr_data);
        m_flag[i] = nf[i]; m_sup[i] = ns[i];
      end
      if (wr_en && wr_addr == 3) begin m_ie[0] = wr_data[0]; m_ie[1] = wr_data[1]; end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int exp_rd;
    case (rd_addr)
      0: exp_rd = m_cmp[0];
      1: exp_rd = m_cmp[1];
      2: exp_rd = m_flag[1] * 2 + m_flag[0];
      default: exp_rd = m_ie[1] * 2 + m_ie[0];
    endcase
    chk(rd_data, exp_rd, "R8 readback");
    for (int i = 0; i < 2; i++) begin
      chk(irq[i], m_flag[i] & m_ie[i], "R3 irq");
      chk(match[i], int'(count) == m_cmp[i], "R1 match");
    end
    chk(at_top, count == 8'hFF, "R1 top");
    chk(at_bottom, count == 8'h00, "R1 bottom");
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
  endtask
  task automatic tk(input logic [7:0] c);
    count = c; tick = 1; cyc(); tick = 0;
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk(rd_data, 0, "R8 reset flags");
    rd_addr = 0; #1 chk(rd_data, 0, "R8 reset compare");
    rd_addr = 2;
    wr(0, 5); wr(1, 9); wr(3, 8'h03);
    rd_addr = 3; #1 chk(rd_data, 3, "R9 enables");
    rd_addr = 2;
    tk(1);
    count = 5; repeat (3) cyc();
    chk(rd_data, 0, "R2 no tick no set");
    tk(5);
    chk(rd_data, 1, "R2 flag set on tick");
    chk(irq, 2'b01, "R3 irq");
    ack = 2'b01; cyc(); ack = 0;
    chk(rd_data, 0, "R4 ack clears");
    tk(5);
    wr(2, 8'h02);
    chk(rd_data, 1, "R5 zero write keeps");
    wr(2, 8'h01);
    chk(rd_data, 0, "R5 one write clears");
    ack = 2'b01; tk(5); ack = 0;
    chk(rd_data, 1, "R6 set beats ack");
    wr_en = 1; wr_addr = 2; wr_data = 1; tk(5); wr_en = 0; wr_data = 0;
    chk(rd_data, 1, "R6 set beats w1c");
    wr(2, 8'h03);
    count = 7; wr(1, 7); tk(7);
    chk(rd_data, 0, "R7 compare write masks");
    tk(7);
    chk(rd_data, 2, "R7 mask lifted");
    wr(2, 8'h03);
    count = 5; cnt_wr = 1; cyc(); cnt_wr = 0; tk(5);
    chk(rd_data, 0, "R7 count write masks");
    tk(5);
    chk(rd_data, 1, "R7 mask lifted count");
    wr(3, 8'h00);
    chk(irq, 0, "R3 disabled irq");
    count = 8'hFF; cyc(); chk(at_top, 1, "R1 top");
    count = 8'h00; cyc(); chk(at_bottom, 1, "R1 bottom");
    for (int n = 0; n < 2000; n++) begin
      tick = $urandom_range(0, 1); count = 8'($urandom_range(0, 7));
      cnt_wr = ($urandom_range(0, 9) == 0); ack = 2'($urandom_range(0, 3)) & {2{$urandom_range(0, 3) == 0}};
      wr_en = ($urandom_range(0, 4) == 0); wr_addr = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom_range(0, 7)); rd_addr = 2'($urandom_range(0, 3));
      cyc();
    end
    tick = 0; cnt_wr = 0; ack = 0; wr_en = 0;
    cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule